// File: doc/BRIEF.md
# LPC Bus Cycle Monitor

This block watches a four-bit multiplexed low-pin-count host bus without ever driving it. On each rising edge of the bus clock it samples the active-low frame strobe and the four data lines. It follows every host-initiated I/O or memory transaction through its phases: the start nibble, the cycle-type nibble, the address nibbles, two turn-around clocks, a sync phase of any length, the two data nibbles and a final pair of turn-around clocks. For a write, the data nibbles come straight after the address. For a read, they come after sync.

When a transaction closes cleanly, the monitor raises a one-clock valid strobe. With it the monitor presents the start code, the three-bit cycle kind, the address, the data byte and the sync code that ended the wait. Protocol problems set sticky warning flags that only the bus reset clears:

- a nibble that changes while the frame strobe is held,
- a reserved cycle kind,
- a turn-around nibble that is not all ones,
- a reserved sync code,
- a sync phase that never ends.

The monitor is meant to be dropped beside a bus as a debug or compliance observer.

Top module: `lpc_cycle_monitor`

## Requirements
- R1: While `bus_rst_n` is low, the monitor is idle, `cyc_valid` is 0 and all five warning flags read 0.
- R2: While `frame_n` is low, the start nibble is re-captured on every clock, and the value seen on the last low clock governs. A captured value of 0000 starts a target transaction. A change of the nibble between two consecutive low clocks sets `warn_start_chg`.
- R3: A governing start value other than 0000 (1111 = abort) returns the monitor to idle, and no transaction is reported for it.
- R4: The nibble on the first clock with `frame_n` high carries the kind in bits [3:1]: 000 I/O read, 001 I/O write, 010 memory read, 011 memory write. This value is reported on `cyc_type`. Kinds 10x end the transaction without a report. Kinds 11x, or bit 0 set, raise `warn_cyc_type`, and 11x also ends it without a report.
- R5: I/O transactions take 4 address nibbles, zero-extended to 32 bits. Memory transactions take 8. The most significant nibble comes first.
- R6: The data byte takes two clocks, low nibble first. For writes it directly follows the address. For reads it directly follows the sync phase.
- R7: Each turn-around lasts exactly two clocks. Any nibble other than 1111 on those clocks sets `warn_tar`, and the transaction is still reported.
- R8: The sync codes 0000 (ready), 1010 (error) and 1001 (ready-more) end the sync phase, and that code is reported on `cyc_sync`. The codes 0101 (short wait) and 0110 (long wait) keep the monitor in sync.
- R9: Any other sync nibble sets `warn_sync_rsvd` and is treated as a wait.
- R10: After `SYNC_TIMEOUT` (default 64) waiting sync clocks in a row, `warn_timeout` is set and the monitor goes idle with no report. After `SYNC_TIMEOUT`-1 waits, an ending code still completes the transaction.
- R11: `cyc_valid` is high for exactly one clock, in the clock after the second trailing turn-around nibble is sampled.
- R12: `frame_n` low in any phase abandons the transaction in progress without a report and re-enters the start phase.
- R13: The warning flags are sticky. Once set, they stay set until `bus_rst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on its rising edge |
| bus_rst_n | input | 1 | Active-low bus reset, asynchronous assert |
| frame_n | input | 1 | Active-low frame strobe observed on the bus |
| lad | input | 4 | Multiplexed address/data/command nibble |
| cyc_valid | output | 1 | One-clock strobe for a completed transaction |
| cyc_start | output | 4 | Governing start nibble of the reported transaction |
| cyc_type | output | 3 | Kind bits [3:1] of the type nibble |
| cyc_addr | output | 32 | Assembled address |
| cyc_data | output | 8 | Assembled data byte |
| cyc_sync | output | 4 | Sync code that ended the wait |
| warn_start_chg | output | 1 | Sticky: start nibble changed while frame held low |
| warn_cyc_type | output | 1 | Sticky: reserved kind or bit 0 set |
| warn_tar | output | 1 | Sticky: turn-around nibble not 1111 |
| warn_sync_rsvd | output | 1 | Sticky: reserved sync code seen |
| warn_timeout | output | 1 | Sticky: sync phase exceeded the limit |

## Verification
The assertions check some properties on every clock:

- the strobe never lasts two clocks;
- a low frame strobe is never followed by a report;
- reports only carry a 0000 start and an I/O or memory kind;
- the flags never fall outside reset;
- a timeout only arises from the sync phase;
- the wait timer is never advanced past its limit.

Only the bench scenarios can show the rest:

- the address length per kind, the nibble ordering and the write/read placement of data;
- that the last held start value wins;
- the exact boundary between 63 and 64 waits;
- that aborts and restarts suppress the report.

// File: rtl/lpcmon_pkg.sv
package lpcmon_pkg;

  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_TAR1,
    ST_SYNC,
    ST_DATA,
    ST_TAR2
  } mon_state_e;

  localparam logic [NIB_W-1:0] START_TARGET = 4'h0;
  localparam logic [NIB_W-1:0] TAR_FLOAT    = 4'hF;
  localparam logic [NIB_W-1:0] SYNC_READY   = 4'h0;
  localparam logic [NIB_W-1:0] SYNC_SHORT   = 4'h5;
  localparam logic [NIB_W-1:0] SYNC_LONG    = 4'h6;
  localparam logic [NIB_W-1:0] SYNC_MORE    = 4'h9;
  localparam logic [NIB_W-1:0] SYNC_ERROR   = 4'hA;

  // Codes that close the sync phase.
  function automatic logic sync_ends(input logic [NIB_W-1:0] code);
    return (code == SYNC_READY) || (code == SYNC_ERROR) || (code == SYNC_MORE);
  endfunction

  // Codes the bus defines as waits.
  function automatic logic sync_known_wait(input logic [NIB_W-1:0] code);
    return (code == SYNC_SHORT) || (code == SYNC_LONG);
  endfunction

endpackage

// File: rtl/lpcmon_rst_sync.sv
module lpcmon_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lpcmon_field_acc.sv
module lpcmon_field_acc #(
  parameter int ADDR_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              data_en_i,
  input  logic              data_hi_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2*NIB_W-1:0] data_o
);
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [2*NIB_W-1:0] data_q, data_d;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (clr_i) begin
      addr_d = '0;
      data_d = '0;
    end else begin
      if (shift_i) addr_d = {addr_q[ADDR_W-NIB_W-1:0], nib_i};
      if (data_en_i) begin
        if (data_hi_i) data_d[2*NIB_W-1:NIB_W] = nib_i;
        else           data_d[NIB_W-1:0]       = nib_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;

  // R6: address and data phases never overlap
  a_r6_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_i && data_en_i));
endmodule

// File: rtl/lpcmon_wait_timer.sv
module lpcmon_wait_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == LAST);

  // R10: the controller never advances the timer once it has expired
  a_r10_tick_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_i && expire_o));
endmodule

// File: rtl/lpc_cycle_monitor.sv
module lpc_cycle_monitor
  import lpcmon_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int IO_ADDR_W    = 16,
  parameter int SYNC_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              bus_rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad,
  output logic              cyc_valid,
  output logic [3:0]        cyc_start,
  output logic [2:0]        cyc_type,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [7:0]        cyc_data,
  output logic [3:0]        cyc_sync,
  output logic              warn_start_chg,
  output logic              warn_cyc_type,
  output logic              warn_tar,
  output logic              warn_sync_rsvd,
  output logic              warn_timeout
);
  localparam int MEM_NIBS = ADDR_W / NIB_W;
  localparam int IO_NIBS  = IO_ADDR_W / NIB_W;
  localparam int CNT_W    = $clog2(MEM_NIBS);
  localparam logic [CNT_W-1:0] MEM_LAST = CNT_W'(MEM_NIBS - 1);
  localparam logic [CNT_W-1:0] IO_LAST  = CNT_W'(IO_NIBS - 1);

  logic rst_n;

  mon_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       start_q, start_d;
  logic [2:0]       type_q, type_d;
  logic [3:0]       sync_q, sync_d;
  logic             valid_q, valid_d;
  logic             w_start_q, w_start_d, w_type_q, w_type_d, w_tar_q, w_tar_d;
  logic             w_sync_q, w_sync_d, w_to_q, w_to_d;

  logic acc_clr, acc_shift, acc_data, tmr_clr, tmr_tick, tmr_expire;
  logic is_wr, is_mem;
  logic [CNT_W-1:0] addr_last;

  lpcmon_rst_sync u_rst (
    .clk    (clk),
    .arst_n (bus_rst_n),
    .srst_n (rst_n)
  );

  lpcmon_field_acc #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (acc_clr),
    .shift_i   (acc_shift),
    .data_en_i (acc_data),
    .data_hi_i (cnt_q[0]),
    .nib_i     (lad),
    .addr_o    (cyc_addr),
    .data_o    (cyc_data)
  );

  lpcmon_wait_timer #(.LIMIT(SYNC_TIMEOUT)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tmr_clr),
    .tick_i   (tmr_tick),
    .expire_o (tmr_expire)
  );

  assign is_wr     = type_q[0];
  assign is_mem    = type_q[1];
  assign addr_last = is_mem ? MEM_LAST : IO_LAST;

  // Next-state process
  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    start_d   = start_q;
    type_d    = type_q;
    sync_d    = sync_q;
    valid_d   = 1'b0;
    w_start_d = w_start_q;
    w_type_d  = w_type_q;
    w_tar_d   = w_tar_q;
    w_sync_d  = w_sync_q;
    w_to_d    = w_to_q;
    acc_clr   = 1'b0;
    acc_shift = 1'b0;
    acc_data  = 1'b0;
    tmr_clr   = 1'b0;
    tmr_tick  = 1'b0;

    if (!frame_n) begin
      // Held or re-asserted frame: (re)capture the start nibble.
      st_d    = ST_START;
      start_d = lad;
      cnt_d   = '0;
      acc_clr = 1'b1;
      if ((st_q == ST_START) && (lad != start_q)) w_start_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_START: begin
          if (start_q != START_TARGET) begin
            st_d = ST_IDLE;
          end else begin
            type_d = lad[3:1];
            if ((lad[3:2] == 2'b11) || lad[0]) w_type_d = 1'b1;
            if (lad[3]) st_d = ST_IDLE;
            else begin
              st_d  = ST_ADDR;
              cnt_d = '0;
            end
          end
        end
        ST_ADDR: begin
          acc_shift = 1'b1;
          if (cnt_q == addr_last) begin
            cnt_d = '0;
            st_d  = is_wr ? ST_DATA : ST_TAR1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          acc_data = 1'b1;
          if (cnt_q[0]) begin
            cnt_d = '0;
            st_d  = is_wr ? ST_TAR1 : ST_TAR2;
          end else begin
            cnt_d = CNT_W'(1);
          end
        end
        ST_TAR1: begin
          if (lad != TAR_FLOAT) w_tar_d = 1'b1;
          if (cnt_q[0]) begin
            cnt_d   = '0;
            st_d    = ST_SYNC;
            tmr_clr = 1'b1;
          end else begin
            cnt_d = CNT_W'(1);
          end
        end
        ST_SYNC: begin
          sync_d = lad;
          if (sync_ends(lad)) begin
            st_d  = is_wr ? ST_TAR2 : ST_DATA;
            cnt_d = '0;
          end else begin
            if (!sync_known_wait(lad)) w_sync_d = 1'b1;
            if (tmr_expire) begin
              w_to_d = 1'b1;
              st_d   = ST_IDLE;
            end else begin
              tmr_tick = 1'b1;
            end
          end
        end
        ST_TAR2: begin
          if (lad != TAR_FLOAT) w_tar_d = 1'b1;
          if (cnt_q[0]) begin
            cnt_d   = '0;
            st_d    = ST_IDLE;
            valid_d = 1'b1;
          end else begin
            cnt_d = CNT_W'(1);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      start_q   <= '0;
      type_q    <= '0;
      sync_q    <= '0;
      valid_q   <= 1'b0;
      w_start_q <= 1'b0;
      w_type_q  <= 1'b0;
      w_tar_q   <= 1'b0;
      w_sync_q  <= 1'b0;
      w_to_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      start_q   <= start_d;
      type_q    <= type_d;
      sync_q    <= sync_d;
      valid_q   <= valid_d;
      w_start_q <= w_start_d;
      w_type_q  <= w_type_d;
      w_tar_q   <= w_tar_d;
      w_sync_q  <= w_sync_d;
      w_to_q    <= w_to_d;
    end
  end

  assign cyc_valid      = valid_q;
  assign cyc_start      = start_q;
  assign cyc_type       = type_q;
  assign cyc_sync       = sync_q;
  assign warn_start_chg = w_start_q;
  assign warn_cyc_type  = w_type_q;
  assign warn_tar       = w_tar_q;
  assign warn_sync_rsvd = w_sync_q;
  assign warn_timeout   = w_to_q;

  // R11: the report strobe lasts a single clock
  a_r11_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R12: a sampled low frame strobe is never followed by a report
  a_r12_frame_blocks_report: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !valid_q);

  // R3: only target transactions are reported
  a_r3_report_target_only: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (start_q == START_TARGET));

  // R4: reported kinds are I/O or memory only
  a_r4_report_kind: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !type_q[2]);

  // R13: warning flags never fall outside reset
  a_r13_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !($fell(w_start_q) || $fell(w_type_q) || $fell(w_tar_q) ||
      $fell(w_sync_q) || $fell(w_to_q)));

  // R10: a timeout can only come out of the sync phase
  a_r10_timeout_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(w_to_q) |-> $past(st_q == ST_SYNC));
endmodule

// File: tb/lpc_cycle_monitor_tb.sv
module lpc_cycle_monitor_tb_top;
  logic        clk;
  logic        bus_rst_n;
  logic        frame_n;
  logic [3:0]  lad;
  logic        cyc_valid;
  logic [3:0]  cyc_start;
  logic [2:0]  cyc_type;
  logic [31:0] cyc_addr;
  logic [7:0]  cyc_data;
  logic [3:0]  cyc_sync;
  logic        warn_start_chg, warn_cyc_type, warn_tar, warn_sync_rsvd, warn_timeout;

  int errors = 0;
  int checks = 0;
  int vcount = 0;
  int cycles = 0;

  lpc_cycle_monitor dut_i (
    .clk            (clk),
    .bus_rst_n      (bus_rst_n),
    .frame_n        (frame_n),
    .lad            (lad),
    .cyc_valid      (cyc_valid),
    .cyc_start      (cyc_start),
    .cyc_type       (cyc_type),
    .cyc_addr       (cyc_addr),
    .cyc_data       (cyc_data),
    .cyc_sync       (cyc_sync),
    .warn_start_chg (warn_start_chg),
    .warn_cyc_type  (warn_cyc_type),
    .warn_tar       (warn_tar),
    .warn_sync_rsvd (warn_sync_rsvd),
    .warn_timeout   (warn_timeout)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (cyc_valid) vcount++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  typedef struct packed {
    logic        mem;
    logic        wr;
    logic [5:0]  waits;
    logic [3:0]  wcode;
    logic [3:0]  fsync;
    logic [31:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 6'd0,  4'h5, 4'h0, 32'h0000_1234, 8'hA5},
    '{1'b0, 1'b1, 6'd2,  4'h5, 4'h0, 32'h0000_BEEF, 8'h3C},
    '{1'b1, 1'b0, 6'd1,  4'h6, 4'h0, 32'hFEDC_BA98, 8'h81},
    '{1'b1, 1'b1, 6'd3,  4'h6, 4'h0, 32'h0012_3400, 8'h7E},
    '{1'b0, 1'b0, 6'd0,  4'h5, 4'hA, 32'h0000_00F0, 8'h5A},
    '{1'b1, 1'b0, 6'd63, 4'h5, 4'h0, 32'h8000_0001, 8'hC3},
    '{1'b0, 1'b1, 6'd0,  4'h5, 4'h9, 32'h0000_0080, 8'h11}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    #1;
    frame_n = fr;
    lad     = nib;
  endtask

  // Releases bus, lets the last sampled nibble take effect, samples outputs.
  task automatic settle();
    drive(1'b1, 4'hF);
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    bus_rst_n = 1'b0;
    frame_n   = 1'b1;
    lad       = 4'hF;
    repeat (3) @(negedge clk);
    bus_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic send_addr(input logic mem, input logic [31:0] a);
    int n = mem ? 8 : 4;
    for (int i = n - 1; i >= 0; i--) drive(1'b1, a[i*4 +: 4]);
  endtask

  task automatic send_data(input logic [7:0] d);
    drive(1'b1, d[3:0]);
    drive(1'b1, d[7:4]);
  endtask

  task automatic send_sync(input int waits, input logic [3:0] wcode, input logic [3:0] fs);
    for (int i = 0; i < waits; i++) drive(1'b1, wcode);
    drive(1'b1, fs);
  endtask

  // Full transaction; last driven nibble is the second trailing turn-around.
  task automatic run_cycle(input logic mem, input logic wr, input logic [31:0] a,
                           input logic [7:0] d, input int waits, input logic [3:0] wcode,
                           input logic [3:0] fs, input logic [3:0] tarv);
    drive(1'b0, 4'h0);
    drive(1'b1, {1'b0, mem, wr, 1'b0});
    send_addr(mem, a);
    if (wr) send_data(d);
    drive(1'b1, tarv);
    drive(1'b1, 4'hF);
    send_sync(waits, wcode, fs);
    if (!wr) send_data(d);
    drive(1'b1, 4'hF);
    drive(1'b1, 4'hF);
  endtask

  initial begin
    int v0;
    logic [31:0] exp_addr;
    bus_rst_n = 1'b1;
    frame_n   = 1'b1;
    lad       = 4'hF;
    @(negedge clk);
    bus_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    // R1: state under reset
    chk(cyc_valid == 1'b0, "R1 valid in reset", 32'(cyc_valid), 0);
    chk({warn_start_chg, warn_cyc_type, warn_tar, warn_sync_rsvd, warn_timeout} == 5'b0,
        "R1 flags in reset",
        32'({warn_start_chg, warn_cyc_type, warn_tar, warn_sync_rsvd, warn_timeout}), 0);
    bus_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // Table walk: R2 R4 R5 R6 R8 R10 R11
    for (int k = 0; k < NVEC; k++) begin
      v0 = vcount;
      exp_addr = VECS[k].mem ? VECS[k].addr : {16'h0, VECS[k].addr[15:0]};
      run_cycle(VECS[k].mem, VECS[k].wr, VECS[k].addr, VECS[k].data,
                int'(VECS[k].waits), VECS[k].wcode, VECS[k].fsync, 4'hF);
      @(negedge clk);
      #1;
      chk(cyc_valid == 1'b1, "R11 strobe after trailing TAR", 32'(cyc_valid), 1);
      chk(cyc_start == 4'h0, "R2 start code", 32'(cyc_start), 0);
      chk(cyc_type == {1'b0, VECS[k].mem, VECS[k].wr}, "R4 kind", 32'(cyc_type),
          32'({1'b0, VECS[k].mem, VECS[k].wr}));
      chk(cyc_addr == exp_addr, "R5 address", cyc_addr, exp_addr);
      chk(cyc_data == VECS[k].data, "R6 data", 32'(cyc_data), 32'(VECS[k].data));
      chk(cyc_sync == VECS[k].fsync, "R8 final sync", 32'(cyc_sync), 32'(VECS[k].fsync));
      @(negedge clk);
      #1;
      chk(vcount - v0 == 1, "R11 single strobe", 32'(vcount - v0), 1);
    end
    chk({warn_start_chg, warn_cyc_type, warn_tar, warn_sync_rsvd, warn_timeout} == 5'b0,
        "R10 R8 clean traffic raises no flag",
        32'({warn_start_chg, warn_cyc_type, warn_tar, warn_sync_rsvd, warn_timeout}), 0);

    // R3: start held 0000 then 1111 last -> abort, no report
    v0 = vcount;
    drive(1'b0, 4'h0);
    drive(1'b0, 4'hF);
    drive(1'b1, 4'h0);
    send_addr(1'b0, 32'h1111);
    drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    send_sync(0, 4'h5, 4'h0);
    send_data(8'h22);
    drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    settle();
    chk(vcount == v0, "R3 abort start gives no report", 32'(vcount - v0), 0);
    chk(warn_start_chg == 1'b1, "R2 start change flagged", 32'(warn_start_chg), 1);

    // R1 R13: bus reset clears flags
    do_reset();
    chk(warn_start_chg == 1'b0, "R1 reset clears flag", 32'(warn_start_chg), 0);

    // R2: last held start value governs (1111 then 0000 -> reported)
    v0 = vcount;
    drive(1'b0, 4'hF);
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h0);
    send_addr(1'b0, 32'h4321);
    drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    send_sync(0, 4'h5, 4'h0);
    send_data(8'h96);
    drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    settle();
    chk(vcount - v0 == 1, "R2 last start wins", 32'(vcount - v0), 1);
    chk(cyc_addr == 32'h4321, "R2 R5 address after held start", cyc_addr, 32'h4321);
    chk(warn_start_chg == 1'b1, "R2 change flagged", 32'(warn_start_chg), 1);

    // R4: reserved kind 1100 -> warning, no report
    do_reset();
    v0 = vcount;
    drive(1'b0, 4'h0);
    drive(1'b1, 4'hC);
    send_addr(1'b0, 32'h0);
    send_data(8'h00);
    settle();
    chk(warn_cyc_type == 1'b1, "R4 reserved kind flagged", 32'(warn_cyc_type), 1);
    chk(vcount == v0, "R4 reserved kind not reported", 32'(vcount - v0), 0);

    // R4: DMA kind 100 -> no report, no flag
    do_reset();
    v0 = vcount;
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h8);
    send_data(8'h00);
    settle();
    chk(vcount == v0 && warn_cyc_type == 1'b0, "R4 DMA kind dropped silently",
        32'({vcount - v0, warn_cyc_type}), 0);

    // R7: bad turn-around still reported, flag set
    v0 = vcount;
    run_cycle(1'b0, 1'b0, 32'h00AA, 8'h55, 0, 4'h5, 4'h0, 4'h7);
    settle();
    chk(vcount - v0 == 1, "R7 cycle still reported", 32'(vcount - v0), 1);
    chk(warn_tar == 1'b1, "R7 turn-around flag", 32'(warn_tar), 1);

    // R9: reserved sync treated as wait and flagged
    do_reset();
    v0 = vcount;
    run_cycle(1'b0, 1'b1, 32'h0C0C, 8'hE7, 2, 4'h3, 4'h0, 4'hF);
    settle();
    chk(vcount - v0 == 1, "R9 reserved sync acts as wait", 32'(vcount - v0), 1);
    chk(cyc_data == 8'hE7, "R9 data intact", 32'(cyc_data), 32'hE7);
    chk(warn_sync_rsvd == 1'b1, "R9 reserved sync flagged", 32'(warn_sync_rsvd), 1);
    chk(warn_timeout == 1'b0, "R10 no timeout on short wait", 32'(warn_timeout), 0);

    // R10: 64 waits -> timeout, idle, no report
    do_reset();
    v0 = vcount;
    run_cycle(1'b0, 1'b0, 32'h0101, 8'h42, 64, 4'h6, 4'h0, 4'hF);
    settle();
    chk(warn_timeout == 1'b1, "R10 timeout flagged", 32'(warn_timeout), 1);
    chk(vcount == v0, "R10 timed-out cycle not reported", 32'(vcount - v0), 0);

    // R12: restart mid-address, then full I/O write
    v0 = vcount;
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h4);
    drive(1'b1, 4'h9); drive(1'b1, 4'h9); drive(1'b1, 4'h9);
    run_cycle(1'b0, 1'b1, 32'h5A5A, 8'h69, 1, 4'h5, 4'h0, 4'hF);
    settle();
    chk(vcount - v0 == 1, "R12 restart reports only new cycle", 32'(vcount - v0), 1);
    chk(cyc_addr == 32'h5A5A, "R12 restarted address", cyc_addr, 32'h5A5A);
    chk(cyc_type == 3'b001, "R12 restarted kind", 32'(cyc_type), 1);

    // R12: frame low during trailing turn-around kills the report
    v0 = vcount;
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h0);
    send_addr(1'b0, 32'h7777);
    drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    send_sync(0, 4'h5, 4'h0);
    send_data(8'h33);
    drive(1'b1, 4'hF);
    drive(1'b0, 4'hF);
    settle();
    chk(vcount == v0, "R12 late frame suppresses report", 32'(vcount - v0), 0);
    chk(warn_timeout == 1'b1, "R13 flag still set", 32'(warn_timeout), 1);

    // R1: reset mid-transaction
    v0 = vcount;
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h2);
    send_addr(1'b0, 32'h1234);
    do_reset();
    drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    settle();
    chk(vcount == v0, "R1 reset abandons transaction", 32'(vcount - v0), 0);
    chk({warn_start_chg, warn_cyc_type, warn_tar, warn_sync_rsvd, warn_timeout} == 5'b0,
        "R1 reset clears all flags",
        32'({warn_start_chg, warn_cyc_type, warn_tar, warn_sync_rsvd, warn_timeout}), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule